// File: doc/BRIEF.md
# Capture-Match Timer Counter

This block is a free-running 32-bit timer whose rate is set by a programmable 32-bit prescaler. Four match channels each compare a programmed value with the counter. When the counter holds that value and the prescaler reaches its terminal count, the match fires. A match can flag an interrupt, stop the count, restart the count from zero, and drive its own output pin in one of four ways. Four capture channels watch external inputs. Each input passes through a synchronizer. On a chosen edge the channel stores the counter value and can flag an interrupt.

Software reaches every register through a simple word-addressed write strobe and an asynchronous read mux. An external pause input freezes the count while it is high. All interrupt flags sit in one status register. A flag clears when software writes a one to it, and the interrupt pin is high while any flag is set.

Top module: `cmt_timer`

## Requirements
- R1: After reset every register reads 0, and the match outputs and the interrupt pin are low.
- R2: While enabled (control bit 0) and not paused, the prescale counter (word 3) runs from 0 to the prescale limit (word 1) and then wraps. On each wrap the counter (word 2) advances by one, so a full prescale period is limit+1 clocks. Control bit 1 holds both counters at zero.
- R3: A match channel i whose reset bit is set (match-control word 4, bit 3i+1) fires when the counter equals its match value (words 8+i) at a prescaler terminal count. The counter then returns to 0, so one full cycle lasts (limit+1)*(match+1) clocks.
- R4: A firing match channel whose stop bit is set (bit 3i+2) leaves the counter at the match value and clears control bit 0.
- R5: A firing match channel sets status bit i (word 7) only when its interrupt bit (bit 3i) is set.
- R6: While the pause input is high, neither the counter nor the prescale counter changes.
- R7: On a firing match, output i follows the 2-bit action in word 5, bits 2i+1:2i. The codes are 00 keep, 01 drive low, 10 drive high and 11 invert.
- R8: Capture input i passes through two synchronizing flops before edge detection. Word 6 bit 3i enables the rising edge and bit 3i+1 enables the falling edge, and either or both may be set. On an enabled edge the counter value is stored in capture word 12+i.
- R9: A capture on channel i sets status bit 4+i only when word 6 bit 3i+2 is set.
- R10: Writing a one to a status bit clears it, and writing a zero leaves it alone. The interrupt pin is the OR of all status bits. If a bit is set and cleared in the same cycle, the set wins.
- R11: The counter, prescale limit, match values and control words read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| cap_in | input | 4 | Capture inputs (asynchronous) |
| pause_in | input | 1 | Holds counting while high |
| match_out | output | 4 | Match-driven outputs |
| irq | output | 1 | OR of all status flags |

## Verification
The two functions that can land on the same clock edge are a new interrupt flag and a software clear of that same flag. The bench raises a capture input at a negative edge. It then counts through the two synchronizer stages and places the write-one-to-clear on exactly the edge where the capture registers. The flag must still be set afterwards, and the interrupt pin must still be high. A second clear that does not collide must then drop both.

// File: rtl/cmt_pkg.sv
// Shared constants for the capture-match timer: register word map and
// output action encoding. Assumes at most four match and four capture channels.
package cmt_pkg;
    localparam int ADDR_W   = 4;
    localparam int A_CTRL   = 0;
    localparam int A_PRESC  = 1;
    localparam int A_COUNT  = 2;
    localparam int A_PCNT   = 3;
    localparam int A_MCTRL  = 4;
    localparam int A_EXTC   = 5;
    localparam int A_CCTRL  = 6;
    localparam int A_INTS   = 7;
    localparam int A_MATCH0 = 8;
    localparam int A_CAP0   = 12;

    typedef enum logic [1:0] {
        EXT_KEEP   = 2'b00,
        EXT_LOW    = 2'b01,
        EXT_HIGH   = 2'b10,
        EXT_TOGGLE = 2'b11
    } ext_act_e;
endpackage

// File: rtl/cmt_prescaler.sv
// Prescale counter: counts 0..limit while run is high and emits a one-cycle
// tick on the terminal count. Assumes clear overrides run.
module cmt_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         tick
);
    logic at_end;

    // Terminal count, tolerant of a limit lowered below the current count.
    assign at_end = (count >= limit);
    assign tick   = run && !clear && at_end;

    // Advance or wrap the prescale count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (run) begin
            count <= at_end ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/cmt_capture.sv
// One capture channel: a two-flop synchronizer, edge detection and a snapshot
// register. Assumes the input is asynchronous to clk.
module cmt_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_en,
    input  logic         fall_en,
    input  logic [W-1:0] count,
    output logic         evt,
    output logic [W-1:0] value
);
    logic s1, s2, s3;

    // Synchronize the pin and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Qualify the detected edge with the enabled directions.
    assign evt = (rise_en && s2 && !s3) || (fall_en && !s2 && s3);

    // Store the counter value on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (evt) begin
            value <= count;
        end
    end
endmodule

// File: rtl/cmt_match.sv
// One match channel: compares the counter at each prescale tick and updates
// its output pin per the 2-bit action. Assumes tick lasts one cycle.
module cmt_match
    import cmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] match_val,
    input  logic [1:0]   action,
    output logic         hit,
    output logic         pin_out
);
    // A match fires on the tick during which the counter holds the value.
    assign hit = tick && (count == match_val);

    // Apply the selected output action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (hit) begin
            case (ext_act_e'(action))
                EXT_LOW:    pin_out <= 1'b0;
                EXT_HIGH:   pin_out <= 1'b1;
                EXT_TOGGLE: pin_out <= !pin_out;
                default:    pin_out <= pin_out;
            endcase
        end
    end
endmodule

// File: rtl/cmt_timer.sv
// Capture-match timer top: register file, counter, and generated match and
// capture channels. Assumes N_MATCH and N_CAP are at most 4 and CNT_W >= 12.
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    input  logic [N_CAP-1:0]   cap_in,
    input  logic               pause_in,
    output logic [N_MATCH-1:0] match_out,
    output logic               irq
);
    localparam int NI = N_MATCH + N_CAP;

    logic                          ctrl_en, ctrl_rst;
    logic [CNT_W-1:0]              presc, pc, tc;
    logic                          tick;
    logic [N_MATCH-1:0][CNT_W-1:0] match_q;
    logic [N_MATCH-1:0]            m_irq_en, m_rst_en, m_stop_en, hit;
    logic [N_MATCH-1:0][1:0]       ext_act;
    logic [N_CAP-1:0]              c_rise_en, c_fall_en, c_irq_en, cap_evt;
    logic [N_CAP-1:0][CNT_W-1:0]   cap_val;
    logic [NI-1:0]                 ints, set_vec, clr_vec;
    logic                          any_rst, any_stop, wr_count, wr_ctrl, wr_ints;

    assign wr_count = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign wr_ints  = bus_wr && (bus_addr == ADDR_W'(A_INTS));

    cmt_prescaler #(.W(CNT_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_en && !pause_in),
        .clear(ctrl_rst), .limit(presc), .count(pc), .tick(tick)
    );

    genvar g;
    generate
        for (g = 0; g < N_MATCH; g++) begin : g_match
            cmt_match #(.W(CNT_W)) u_match (
                .clk(clk), .rst_n(rst_n), .tick(tick), .count(tc),
                .match_val(match_q[g]), .action(ext_act[g]),
                .hit(hit[g]), .pin_out(match_out[g])
            );
        end
        for (g = 0; g < N_CAP; g++) begin : g_cap
            cmt_capture #(.W(CNT_W)) u_cap (
                .clk(clk), .rst_n(rst_n), .pin(cap_in[g]),
                .rise_en(c_rise_en[g]), .fall_en(c_fall_en[g]), .count(tc),
                .evt(cap_evt[g]), .value(cap_val[g])
            );
        end
    endgenerate

    assign any_rst  = |(hit & m_rst_en);
    assign any_stop = |(hit & m_stop_en);

    // Main counter: bus write, hold-clear, then tick-driven advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc <= '0;
        end else if (wr_count) begin
            tc <= bus_wdata;
        end else if (ctrl_rst) begin
            tc <= '0;
        end else if (tick) begin
            if (any_rst)       tc <= '0;
            else if (!any_stop) tc <= tc + 1'b1;
        end
    end

    // Control word: software write, or enable cleared by a stopping match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en  <= 1'b0;
            ctrl_rst <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_en  <= bus_wdata[0];
            ctrl_rst <= bus_wdata[1];
        end else if (tick && any_stop) begin
            ctrl_en  <= 1'b0;
        end
    end

    // Configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc     <= '0;
            match_q   <= '0;
            m_irq_en  <= '0;
            m_rst_en  <= '0;
            m_stop_en <= '0;
            ext_act   <= '0;
            c_rise_en <= '0;
            c_fall_en <= '0;
            c_irq_en  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_PRESC)) presc <= bus_wdata;
            for (int i = 0; i < N_MATCH; i++) begin
                if (bus_addr == ADDR_W'(A_MATCH0 + i)) match_q[i] <= bus_wdata;
                if (bus_addr == ADDR_W'(A_MCTRL)) begin
                    m_irq_en[i]  <= bus_wdata[3*i];
                    m_rst_en[i]  <= bus_wdata[3*i+1];
                    m_stop_en[i] <= bus_wdata[3*i+2];
                end
                if (bus_addr == ADDR_W'(A_EXTC)) ext_act[i] <= bus_wdata[2*i +: 2];
            end
            for (int i = 0; i < N_CAP; i++) begin
                if (bus_addr == ADDR_W'(A_CCTRL)) begin
                    c_rise_en[i] <= bus_wdata[3*i];
                    c_fall_en[i] <= bus_wdata[3*i+1];
                    c_irq_en[i]  <= bus_wdata[3*i+2];
                end
            end
        end
    end

    assign set_vec = {cap_evt & c_irq_en, hit & m_irq_en};
    assign clr_vec = wr_ints ? bus_wdata[NI-1:0] : '0;

    // Interrupt flags: write-one clears, a same-cycle set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ints <= '0;
        end else begin
            ints <= (ints & ~clr_vec) | set_vec;
        end
    end

    assign irq = |ints;

    // Read mux over the register word map.
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            A_CTRL:  bus_rdata[1:0] = {ctrl_rst, ctrl_en};
            A_PRESC: bus_rdata = presc;
            A_COUNT: bus_rdata = tc;
            A_PCNT:  bus_rdata = pc;
            A_MCTRL:
                for (int i = 0; i < N_MATCH; i++)
                    bus_rdata[3*i +: 3] = {m_stop_en[i], m_rst_en[i], m_irq_en[i]};
            A_EXTC:
                for (int i = 0; i < N_MATCH; i++) bus_rdata[2*i +: 2] = ext_act[i];
            A_CCTRL:
                for (int i = 0; i < N_CAP; i++)
                    bus_rdata[3*i +: 3] = {c_irq_en[i], c_fall_en[i], c_rise_en[i]};
            A_INTS:  bus_rdata[NI-1:0] = ints;
            default: begin
                for (int i = 0; i < N_MATCH; i++)
                    if (int'(bus_addr) == A_MATCH0 + i) bus_rdata = match_q[i];
                for (int i = 0; i < N_CAP; i++)
                    if (int'(bus_addr) == A_CAP0 + i) bus_rdata = cap_val[i];
            end
        endcase
    end
endmodule

// File: rtl/cmt_timer_chk.sv
// Assertion checker for cmt_timer, bound to every instance of the top.
module cmt_timer_chk
    import cmt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int N_MATCH = 4,
    parameter int N_CAP   = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            pause_in,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [CNT_W-1:0]                bus_wdata,
    input logic [CNT_W-1:0]                tc,
    input logic                            ctrl_en,
    input logic                            ctrl_rst,
    input logic                            tick,
    input logic [N_MATCH-1:0]              hit,
    input logic [N_MATCH-1:0]              m_rst_en,
    input logic [N_MATCH-1:0]              m_stop_en,
    input logic [N_CAP-1:0]                cap_evt,
    input logic [N_CAP-1:0][CNT_W-1:0]     cap_val,
    input logic [N_MATCH+N_CAP-1:0]        ints,
    input logic [N_MATCH+N_CAP-1:0]        set_vec
);
    localparam int NI = N_MATCH + N_CAP;

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_in && !bus_wr && !ctrl_rst) |=> (tc == $past(tc))); // R6

    AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && |(hit & m_stop_en) && !bus_wr) |=> !ctrl_en); // R4

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && |(hit & m_rst_en) && !bus_wr) |=> (tc == '0)); // R3

    genvar b;
    generate
        for (b = 0; b < NI; b++) begin : g_flag
            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == ADDR_W'(A_INTS) && bus_wdata[b] && !set_vec[b])
                |=> !ints[b]); // R10
            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[b] |=> ints[b]); // R10
        end
        for (b = 0; b < N_CAP; b++) begin : g_capchk
            AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                cap_evt[b] |=> (cap_val[b] == $past(tc))); // R8
        end
    endgenerate
endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .N_CAP(N_CAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .pause_in(pause_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tc(tc), .ctrl_en(ctrl_en),
    .ctrl_rst(ctrl_rst), .tick(tick), .hit(hit), .m_rst_en(m_rst_en),
    .m_stop_en(m_stop_en), .cap_evt(cap_evt), .cap_val(cap_val),
    .ints(ints), .set_vec(set_vec)
);

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic        pause_in = 1'b0;
    logic [3:0]  match_out;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    cmt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .pause_in(pause_in), .match_out(match_out), .irq(irq)
    );

    always #10 clk = !clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Negedges until match_out[0] changes.
    task automatic until_toggle(output int n);
        logic prev;
        prev = match_out[0];
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            n++;
            if (match_out[0] != prev) break;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, b;
        int n;
        wait_cyc(3);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk($sformatf("R1 reg%0d", i), v, 0);
        end
        chk("R1 match_out", 32'(match_out), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2 R3: sweep of prescale limit and reset-on-match value
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 4; m++) begin
                wr(0, 2);
                wr(1, p);
                wr(8, m);
                wr(4, 32'h2);
                wr(5, 32'h3);
                wr(0, 1);
                until_toggle(n);
                until_toggle(n);
                chk($sformatf("R2 R3 period p=%0d m=%0d", p, m), n, (p + 1) * (m + 1));
            end
        end
        wr(0, 0);

        // R11: readback
        wr(10, 32'hDEADBEEF);
        rd(10, v); chk("R11 match2", v, 32'hDEADBEEF);
        rd(1, v);  chk("R11 presc", v, 3);
        rd(4, v);  chk("R11 mctrl", v, 32'h2);
        rd(5, v);  chk("R11 extc", v, 32'h3);

        // R4 R5: stop on match with interrupt on channel 1
        wr(0, 2); wr(1, 0); wr(9, 5); wr(5, 0);
        wr(4, 32'h28);
        wr(7, 32'hFF);
        wr(0, 1);
        wait_cyc(20);
        rd(2, v); chk("R4 count held at match", v, 5);
        rd(0, v); chk("R4 enable cleared", v, 0);
        rd(7, v); chk("R5 match flag bit1", v, 32'h2);
        chk("R10 irq high", 32'(irq), 1);
        wr(7, 32'h1);
        rd(7, v); chk("R10 write other bit no effect", v, 32'h2);
        wr(7, 32'h2);
        rd(7, v); chk("R10 cleared", v, 0);
        chk("R10 irq low", 32'(irq), 0);

        // R7: output actions, one stopping match per round, no interrupts
        wr(8, 3); wr(9, 3); wr(10, 3); wr(11, 3);
        wr(4, 32'h4);
        wr(0, 2); wr(5, 32'hD8); wr(0, 1); wait_cyc(12);
        chk("R7 round1 keep/high/low/toggle", 32'(match_out), 32'hA);
        wr(0, 2); wr(5, 32'hE2); wr(0, 1); wait_cyc(12);
        chk("R7 round2 high/keep/high/toggle", 32'(match_out), 32'h7);
        wr(0, 2); wr(5, 32'hC5); wr(0, 1); wait_cyc(12);
        chk("R7 round3 low/low/keep/toggle", 32'(match_out), 32'hC);
        rd(7, v); chk("R5 no flag without enable", v, 0);

        // R6: pause
        wr(0, 2); wr(4, 0); wr(1, 0); wr(0, 1);
        wait_cyc(10);
        pause_in = 1'b1;
        wait_cyc(2);
        rd(2, a);
        wait_cyc(20);
        rd(2, b);
        chk("R6 count frozen", b, a);
        pause_in = 1'b0;
        wait_cyc(10);
        rd(2, v);
        chk("R6 resumes", 32'(v != b), 1);
        wr(0, 0);

        // R8 R9: capture edges with the counter stopped
        wr(6, 32'hD5);
        wr(7, 32'hFF);
        wr(2, 32'h11);
        @(negedge clk) cap_in = 4'hF;
        wait_cyc(5);
        rd(12, v); chk("R8 rise ch0", v, 32'h11);
        rd(13, v); chk("R8 fall-only ch1 ignores rise", v, 0);
        rd(14, v); chk("R8 both ch2 rise", v, 32'h11);
        rd(15, v); chk("R8 disabled ch3", v, 0);
        rd(7, v);  chk("R9 cap flag ch0 only", v, 32'h10);
        wr(2, 32'h22);
        @(negedge clk) cap_in = 4'h0;
        wait_cyc(5);
        rd(12, v); chk("R8 rise-only ch0 ignores fall", v, 32'h11);
        rd(13, v); chk("R8 fall ch1", v, 32'h22);
        rd(14, v); chk("R8 both ch2 fall", v, 32'h22);
        rd(15, v); chk("R8 disabled ch3 after fall", v, 0);
        rd(7, v);  chk("R9 no flag without enable", v, 32'h10);

        // R10: capture flag set on the same edge as its clear
        wr(7, 32'hFF);
        wr(2, 32'h33);
        @(negedge clk) cap_in = 4'h1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h10;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(7, v);  chk("R10 set wins over clear", v, 32'h10);
        chk("R10 irq stays high", 32'(irq), 1);
        rd(12, v); chk("R8 capture at collision", v, 32'h33);
        wr(7, 32'h10);
        rd(7, v);  chk("R10 later clear", v, 0);
        chk("R10 irq low after clear", 32'(irq), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule